// File: doc/BRIEF.md
# Power-Down Classifier and DLL/ODT Condition Tracker

This block sits beside a DRAM command scheduler and decides what kind of power-down the memory device is in once the scheduler asks to drop the clock enable. The scheduler states the clock-enable level it wants and says whether a command is still in flight. When nothing is in flight, the block takes the open-bank bitmap and the configured exit speed, and from these it picks active, slow-exit precharge or fast-exit precharge power-down. It then drives the real clock-enable level to the device.

While the device is down, the block reports whether the delay-locked loop is running. It reports whether on-die termination must be handled as asynchronous, and whether the device input/output buffers are off yet. For slow-exit precharge power-down, the asynchronous-termination window opens a programmable lead before the clock enable falls. The window then stays open for a programmable tail after the clock enable rises again. If the loop was not locked when power-down was committed, the block raises a sticky request to reset it after exit.

Top module: `pd_power_tracker`

## Requirements
- R1: With no bank open and the slow-exit bit set, the committed mode is precharge-slow (pd_mode_o = 2'b10), and dll_on_o is low while down and during the exit window that follows.
- R2: With no bank open and the slow-exit bit clear, the committed mode is precharge-fast (pd_mode_o = 2'b11), dll_on_o stays high and odt_async_o stays low.
- R3: With any bit of bank_open_i set, the committed mode is active (pd_mode_o = 2'b01) whatever the slow-exit bit, with dll_on_o high and odt_async_o low.
- R4: While cmd_busy_i is high, entry waits. The mode is chosen from bank_open_i and slow_exit_i on the first clock on which cmd_busy_i is low.
- R5: For a precharge-slow commit, odt_async_o rises on the commit clock and cke_o falls anpd_cyc_i clocks later. For the other modes, cke_o falls on the commit clock. pd_mode_o is 2'b00 whenever cke_o is high.
- R6: bufs_off_o rises exactly CPDED_CYC clocks after cke_o falls, and is low whenever cke_o is high.
- R7: A high cke_req_i while down raises cke_o and returns pd_mode_o to 2'b00 on the next clock. After a precharge-slow exit, odt_async_o stays high for exactly anpd_cyc_i + xpdll_cyc_i clocks counted from that clock.
- R8: dll_reset_req_o is set at exit when dll_locked_i was low at the commit clock. It is cleared on a rising edge of dll_locked_i, and it is never set when the loop was locked at commit.
- R9: Out of reset, cke_o = 1, pd_mode_o = 2'b00, dll_on_o = 1, and odt_async_o, bufs_off_o and dll_reset_req_o are 0.
- R10: An entry request withdrawn (cke_req_i high again) before cmd_busy_i falls causes no entry.
- R11: A low cke_req_i during the post-exit window is held off until the window closes, and is then committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_req_i | input | 1 | Clock-enable level requested by the scheduler (0 asks for power-down) |
| cmd_busy_i | input | 1 | A command is still in progress |
| bank_open_i | input | NBANK | One bit per bank, 1 = row open |
| slow_exit_i | input | 1 | 1 = precharge power-down uses slow exit |
| dll_locked_i | input | 1 | Loop lock indication |
| anpd_cyc_i | input | TW | Asynchronous-termination lead, in clocks |
| xpdll_cyc_i | input | TW | Loop relock exit time, in clocks |
| cke_o | output | 1 | Clock enable driven to the device |
| pd_mode_o | output | 2 | 00 none, 01 active, 10 precharge-slow, 11 precharge-fast |
| dll_on_o | output | 1 | Loop is running |
| odt_async_o | output | 1 | Termination must be treated as asynchronous |
| bufs_off_o | output | 1 | Device input/output buffers are disabled |
| dll_reset_req_o | output | 1 | Loop reset required before reads or synchronous termination |

## Verification
The hardest situation to reach is a request that arrives during the slow-exit tail. It needs a full slow entry, a lead countdown, an exit, and a new low request placed while the tail is still counting. The stimulus chains those phases back to back and drops the request on the first clock after exit. It then checks that nothing happens until the window closes and that the commit follows on the next clock. The deferred classification is reached by holding the busy input high while banks are open and closing them on the same clock the busy input falls.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PDM_NONE     = 2'b00,
    PDM_ACTIVE   = 2'b01,
    PDM_PRE_SLOW = 2'b10,
    PDM_PRE_FAST = 2'b11
  } pd_mode_e;

  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_HOLD  = 3'd1,
    ST_LEAD  = 3'd2,
    ST_DOWN  = 3'd3,
    ST_TAIL  = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pd_classify.sv
module pd_classify
  import pd_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int GROUP = 4
) (
  input  logic [NBANK-1:0] bank_open_i,
  input  logic             slow_exit_i,
  output pd_mode_e         mode_o
);
  localparam int NGRP = (NBANK + GROUP - 1) / GROUP;

  logic [NGRP-1:0] grp_any;

  // first-level reduction in groups to keep the OR tree shallow for wide maps
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = ((g + 1) * GROUP > NBANK) ? NBANK - 1 : (g + 1) * GROUP - 1;
    assign grp_any[g] = |bank_open_i[HI:LO];
  end

  always_comb begin
    if (|grp_any)         mode_o = PDM_ACTIVE;
    else if (slow_exit_i) mode_o = PDM_PRE_SLOW;
    else                  mode_o = PDM_PRE_FAST;
  end
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int TW        = 8,
  parameter int CPDED_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_req_i,
  input  logic          busy_i,
  input  pd_mode_e      class_i,
  input  logic          dll_locked_i,
  input  logic [TW-1:0] anpd_i,
  input  logic [TW-1:0] xpdll_i,
  output logic          cke_o,
  output pd_mode_e      mode_o,
  output logic          dll_on_o,
  output logic          odt_async_o,
  output logic          bufs_off_o,
  output logic          exit_o,
  output logic          unlocked_o
);
  localparam int            CW  = TW + 1;
  localparam logic [CW-1:0] CPD = CW'(CPDED_CYC);
  localparam logic [CW-1:0] ONE = CW'(1);

  pd_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  pd_mode_e      mode_q;
  logic          lock_q;
  logic          commit;
  logic          slow_q;
  logic [CW-1:0] win_len;
  logic [CW-1:0] lead_len;

  assign win_len  = {1'b0, anpd_i} + {1'b0, xpdll_i};
  assign lead_len = {1'b0, anpd_i};
  assign slow_q   = (mode_q == PDM_PRE_SLOW);
  assign commit   = ((st_q == ST_AWAKE) || (st_q == ST_HOLD)) && !cke_req_i && !busy_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_AWAKE, ST_HOLD: begin
        if (cke_req_i)   st_n = ST_AWAKE;
        else if (busy_i) st_n = ST_HOLD;
        else if ((class_i == PDM_PRE_SLOW) && (lead_len != '0)) begin
          st_n  = ST_LEAD;
          cnt_n = lead_len;
        end else begin
          st_n  = ST_DOWN;
          cnt_n = '0;
        end
      end
      ST_LEAD: begin
        if (cnt_q == ONE) begin
          st_n  = ST_DOWN;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
      ST_DOWN: begin
        if (cke_req_i) begin
          if (slow_q && (win_len != '0)) begin
            st_n  = ST_TAIL;
            cnt_n = win_len;
          end else begin
            st_n  = ST_AWAKE;
            cnt_n = '0;
          end
        end else if (cnt_q < CPD) begin
          cnt_n = cnt_q + ONE;
        end
      end
      ST_TAIL: begin
        if (cnt_q == ONE) begin
          st_n  = ST_AWAKE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
      default: begin
        st_n  = ST_AWAKE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  // mode and lock capture are enabled only by the commit decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PDM_NONE;
      lock_q <= 1'b1;
    end else if (commit) begin
      mode_q <= class_i;
      lock_q <= dll_locked_i;
    end
  end

  assign cke_o       = (st_q != ST_DOWN);
  assign mode_o      = (st_q == ST_DOWN) ? mode_q : PDM_NONE;
  assign odt_async_o = (st_q == ST_LEAD) || (st_q == ST_TAIL) || ((st_q == ST_DOWN) && slow_q);
  assign dll_on_o    = !(((st_q == ST_DOWN) || (st_q == ST_TAIL)) && slow_q);
  assign bufs_off_o  = (st_q == ST_DOWN) && (cnt_q == CPD);
  assign exit_o      = (st_q == ST_DOWN) && cke_req_i;
  assign unlocked_o  = !lock_q;
endmodule

// File: rtl/pd_dll_flag.sv
module pd_dll_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic exit_i,
  input  logic unlocked_i,
  input  logic dll_locked_i,
  output logic need_rst_o
);
  logic flag_q, flag_n;
  logic lock_prev_q;
  logic set_c, clr_c;

  assign set_c = exit_i && unlocked_i;
  assign clr_c = dll_locked_i && !lock_prev_q;

  always_comb begin
    flag_n = flag_q;
    if (set_c)      flag_n = 1'b1;
    else if (clr_c) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q      <= 1'b0;
      lock_prev_q <= 1'b1;
    end else begin
      flag_q      <= flag_n;
      lock_prev_q <= dll_locked_i;
    end
  end

  assign need_rst_o = flag_q;
endmodule

// File: rtl/pd_power_tracker.sv
module pd_power_tracker
  import pd_pkg::*;
#(
  parameter int NBANK     = 8,
  parameter int TW        = 8,
  parameter int CPDED_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_req_i,
  input  logic             cmd_busy_i,
  input  logic [NBANK-1:0] bank_open_i,
  input  logic             slow_exit_i,
  input  logic             dll_locked_i,
  input  logic [TW-1:0]    anpd_cyc_i,
  input  logic [TW-1:0]    xpdll_cyc_i,
  output logic             cke_o,
  output logic [1:0]       pd_mode_o,
  output logic             dll_on_o,
  output logic             odt_async_o,
  output logic             bufs_off_o,
  output logic             dll_reset_req_o
);
  logic     rst_int_n;
  pd_mode_e class_mode;
  pd_mode_e cur_mode;
  logic     exit_p;
  logic     unlocked;

  pd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pd_classify #(.NBANK(NBANK)) u_cls (
    .bank_open_i (bank_open_i),
    .slow_exit_i (slow_exit_i),
    .mode_o      (class_mode)
  );

  pd_seq #(.TW(TW), .CPDED_CYC(CPDED_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cke_req_i    (cke_req_i),
    .busy_i       (cmd_busy_i),
    .class_i      (class_mode),
    .dll_locked_i (dll_locked_i),
    .anpd_i       (anpd_cyc_i),
    .xpdll_i      (xpdll_cyc_i),
    .cke_o        (cke_o),
    .mode_o       (cur_mode),
    .dll_on_o     (dll_on_o),
    .odt_async_o  (odt_async_o),
    .bufs_off_o   (bufs_off_o),
    .exit_o       (exit_p),
    .unlocked_o   (unlocked)
  );

  pd_dll_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .exit_i       (exit_p),
    .unlocked_i   (unlocked),
    .dll_locked_i (dll_locked_i),
    .need_rst_o   (dll_reset_req_o)
  );

  assign pd_mode_o = cur_mode;
endmodule

// File: rtl/pd_chk.sv
module pd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_req_i,
  input logic       cke_o,
  input logic [1:0] pd_mode_o,
  input logic       dll_on_o,
  input logic       odt_async_o,
  input logic       bufs_off_o,
  input logic       dll_reset_req_o
);
  // R1
  slow_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o == 2'b10) |-> (!dll_on_o && odt_async_o));

  // R2
  fast_dll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o == 2'b11) |-> (dll_on_o && !odt_async_o));

  // R3
  active_dll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o == 2'b01) |-> (dll_on_o && !odt_async_o));

  // R5
  mode_needs_low_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o != 2'b00) |-> !cke_o);

  // R6
  bufs_only_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bufs_off_o |-> (!cke_o && pd_mode_o != 2'b00));

  // R6
  bufs_not_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> !bufs_off_o);

  // R7
  exit_next_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && cke_req_i) |=> (cke_o && pd_mode_o == 2'b00));

  // R8
  dll_reset_at_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_reset_req_o) |-> $rose(cke_o));
endmodule

bind pd_power_tracker pd_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_int_n),
  .cke_req_i       (cke_req_i),
  .cke_o           (cke_o),
  .pd_mode_o       (pd_mode_o),
  .dll_on_o        (dll_on_o),
  .odt_async_o     (odt_async_o),
  .bufs_off_o      (bufs_off_o),
  .dll_reset_req_o (dll_reset_req_o)
);

// File: tb/sim_pd_power_tracker.sv
`timescale 1ns/1ps
module sim_pd_power_tracker;
  localparam int NBANK = 8;
  localparam int TW    = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cke_req_i;
  logic             cmd_busy_i;
  logic [NBANK-1:0] bank_open_i;
  logic             slow_exit_i;
  logic             dll_locked_i;
  logic [TW-1:0]    anpd_cyc_i;
  logic [TW-1:0]    xpdll_cyc_i;
  logic             cke_o;
  logic [1:0]       pd_mode_o;
  logic             dll_on_o;
  logic             odt_async_o;
  logic             bufs_off_o;
  logic             dll_reset_req_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    string      tag;
    logic [6:0] exp;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pd_power_tracker #(.NBANK(NBANK), .TW(TW), .CPDED_CYC(3)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .cke_req_i       (cke_req_i),
    .cmd_busy_i      (cmd_busy_i),
    .bank_open_i     (bank_open_i),
    .slow_exit_i     (slow_exit_i),
    .dll_locked_i    (dll_locked_i),
    .anpd_cyc_i      (anpd_cyc_i),
    .xpdll_cyc_i     (xpdll_cyc_i),
    .cke_o           (cke_o),
    .pd_mode_o       (pd_mode_o),
    .dll_on_o        (dll_on_o),
    .odt_async_o     (odt_async_o),
    .bufs_off_o      (bufs_off_o),
    .dll_reset_req_o (dll_reset_req_o)
  );

  // expected vector layout: {cke, mode[1:0], dll_on, odt_async, bufs_off, dll_reset_req}
  task automatic expect_out(input string tag, input logic [6:0] v);
    item_t it;
    it.tag = tag;
    it.exp = v;
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [6:0] act;
      it  = sb_q.pop_front();
      act = {cke_o, pd_mode_o, dll_on_o, odt_async_o, bufs_off_o, dll_reset_req_o};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(60000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    cke_req_i    = 1'b1;
    cmd_busy_i   = 1'b0;
    bank_open_i  = '0;
    slow_exit_i  = 1'b1;
    dll_locked_i = 1'b1;
    anpd_cyc_i   = 8'd2;
    xpdll_cyc_i  = 8'd4;
    tick(3);
    expect_out("R9 in reset", 7'b1_00_1_0_0_0);
    rst_n = 1'b1;
    tick(4);
    expect_out("R9 after reset", 7'b1_00_1_0_0_0);

    // slow-exit precharge entry and exit
    cke_req_i = 1'b0;
    tick; expect_out("R5 lead window opens", 7'b1_00_1_1_0_0);
    tick; expect_out("R5 lead still high cke", 7'b1_00_1_1_0_0);
    tick; expect_out("R1 slow precharge down", 7'b0_10_0_1_0_0);
    tick(2); expect_out("R6 bufs not yet off", 7'b0_10_0_1_0_0);
    tick; expect_out("R6 bufs off after delay", 7'b0_10_0_1_1_0);
    cke_req_i = 1'b1;
    tick; expect_out("R7 exit next clock", 7'b1_00_0_1_0_0);
    tick(5); expect_out("R7 window last clock", 7'b1_00_0_1_0_0);
    tick; expect_out("R7 window closed, R8 no reset req", 7'b1_00_1_0_0_0);

    // deferred classification while busy
    cmd_busy_i  = 1'b1;
    bank_open_i = 8'h01;
    cke_req_i   = 1'b0;
    tick; expect_out("R4 held while busy", 7'b1_00_1_0_0_0);
    tick; expect_out("R4 still held", 7'b1_00_1_0_0_0);
    cmd_busy_i  = 1'b0;
    bank_open_i = 8'h00;
    tick; expect_out("R4 classified at busy low", 7'b1_00_1_1_0_0);
    tick(2); expect_out("R4 slow down", 7'b0_10_0_1_0_0);
    cke_req_i = 1'b1;
    tick; expect_out("R11 tail begins", 7'b1_00_0_1_0_0);
    cke_req_i = 1'b0;
    tick(5); expect_out("R11 request held in tail", 7'b1_00_0_1_0_0);
    tick; expect_out("R11 awake after tail", 7'b1_00_1_0_0_0);
    tick; expect_out("R11 commit after tail", 7'b1_00_1_1_0_0);
    tick(2); expect_out("R1 re-entered", 7'b0_10_0_1_0_0);
    cke_req_i = 1'b1;
    tick(7); expect_out("R7 back awake", 7'b1_00_1_0_0_0);

    // fast exit with unlocked loop
    dll_locked_i = 1'b0;
    slow_exit_i  = 1'b0;
    cke_req_i    = 1'b0;
    tick; expect_out("R2 fast precharge down", 7'b0_11_1_0_0_0);
    tick(3); expect_out("R6 fast bufs off", 7'b0_11_1_0_1_0);
    cke_req_i = 1'b1;
    tick; expect_out("R8 reset req after unlocked exit", 7'b1_00_1_0_0_1);
    tick; expect_out("R8 reset req sticky", 7'b1_00_1_0_0_1);
    dll_locked_i = 1'b1;
    tick; expect_out("R8 cleared on lock rise", 7'b1_00_1_0_0_0);

    // active power-down
    bank_open_i = 8'h80;
    slow_exit_i = 1'b1;
    cke_req_i   = 1'b0;
    tick; expect_out("R3 active down", 7'b0_01_1_0_0_0);
    cke_req_i = 1'b1;
    tick; expect_out("R7 active exit", 7'b1_00_1_0_0_0);
    bank_open_i = 8'h00;

    // withdrawn request
    cmd_busy_i = 1'b1;
    cke_req_i  = 1'b0;
    tick; expect_out("R10 waiting", 7'b1_00_1_0_0_0);
    cke_req_i = 1'b1;
    tick; expect_out("R10 withdrawn", 7'b1_00_1_0_0_0);
    cmd_busy_i = 1'b0;
    tick; expect_out("R10 no entry", 7'b1_00_1_0_0_0);
    tick; expect_out("R10 still awake", 7'b1_00_1_0_0_0);

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule